// File: doc/BRIEF.md
# DMA Region Protection Checker

This block sits between one DMA bus master and the memory fabric and decides, for every master request, whether it may proceed. It holds a small bank of 64-bit protection entries. Each entry describes a naturally aligned power-of-two region and the read, write and execute rights that apply to it. Software programs the entries through a plain register write port and can read them back through a registered read port.

For each request (start address, byte length, access rights), every entry decodes its own region from the trailing ones of its address field and tests whether the whole span lies inside it. The lowest-numbered entry that contains the span decides. The request is granted only when that entry's rights equal the requested rights exactly. An entry whose lock bit is set can no longer be changed. After reset no entry is active, so every request is denied until software programs one.

Top module: `dma_napot_guard`

## Requirements
- R1: After reset every entry reads as zero and every request is answered with resp_grant=0 and resp_hit=0.
- R2: An entry keeps the written bits [63:56] (mode byte) and [35:0] (region field); bits [55:36] always read back as zero. cfg_rdata shows the entry selected by cfg_raddr one clock later.
- R3: When bit 7 of an entry's mode byte (entry bit 63) is set, later writes to that entry leave it unchanged and its region keeps deciding requests as before.
- R4: A write whose cfg_waddr is N_ENTRIES or higher changes no entry; a read of such an address returns zero.
- R5: In the mode byte, bit 0 is read, bit 1 is write, bit 2 is execute and bits [4:3] select the address mode; only the value 3 (naturally aligned power-of-two) enables the entry, any other value makes it match nothing.
- R6: An entry whose region field ends in t one bits covers 2^(t+3) bytes starting at the field with those t bits cleared, shifted left by 2 (so 0x5FF covers 0x1000 to 0x1FFF and 36 field bits address 38 address bits).
- R7: An entry contains a request only when req_addr is at least its base and req_addr + req_len is at most base + size.
- R8: A request is granted only when the 3-bit req_perm ({X,W,R}) equals the deciding entry's rights bits exactly.
- R9: Among the entries that contain a request, the lowest-numbered one decides and is reported on resp_idx; with no containing entry the request is denied with resp_hit=0 and resp_idx=0.
- R10: resp_valid is high exactly one clock after a cycle with req_valid high, and resp_grant, resp_hit and resp_idx are zero in any cycle after req_valid was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_waddr | input | CFG_AW | Entry index for writes |
| cfg_wdata | input | 64 | Entry write data |
| cfg_raddr | input | CFG_AW | Entry index for reads |
| cfg_rdata | output | 64 | Registered entry read data |
| req_valid | input | 1 | Master request present |
| req_addr | input | 38 | Request start byte address |
| req_len | input | LEN_W | Request length in bytes |
| req_perm | input | 3 | Requested rights {X,W,R} |
| resp_valid | output | 1 | Decision valid |
| resp_grant | output | 1 | Request allowed |
| resp_hit | output | 1 | Some entry contained the request |
| resp_idx | output | IDX_W | Deciding entry index |

## Verification
The request table uses four overlapping regions of different sizes: spans that end exactly on a region's upper boundary against spans one word past it tell an inclusive end from an off-by-one limit, spans that start just below a region tell a base compare from a masked one, and requests inside two regions with differing rights tell lowest-index priority from any-entry-allows logic. Rights that are a strict subset of an entry's rights separate exact-match checking from subset checking. Directed cases cover a near-full-space region from 35 trailing ones, an entry disabled by a non-NAPOT mode value, writes to a locked entry and to an index past the bank.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  localparam int ENTRY_W  = 64;
  localparam int NAPOT_W  = 36;
  localparam int MODE_W   = 8;
  localparam int MODE_LSB = 56;
  localparam int ADDR_W   = NAPOT_W + 2;
  localparam int SPAN_W   = ADDR_W + 2;
  localparam int TCNT_W   = $clog2(NAPOT_W + 1);

  localparam logic [1:0] AMODE_NAPOT = 2'b11;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsv;
    logic [1:0] amode;
    logic       x;
    logic       w;
    logic       r;
  } mode_t;

  function automatic logic [TCNT_W-1:0] trail_ones(input logic [NAPOT_W-1:0] v);
    logic [TCNT_W-1:0] n;
    logic              run;
    n   = '0;
    run = 1'b1;
    for (int i = 0; i < NAPOT_W; i++) begin
      if (run && v[i]) n = n + TCNT_W'(1);
      else             run = 1'b0;
    end
    return n;
  endfunction

endpackage

// File: rtl/mpc_cfg_bank.sv
module mpc_cfg_bank
  import mpc_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int CFG_AW    = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [CFG_AW-1:0]               wr_addr,
  input  logic [ENTRY_W-1:0]              wr_data,
  input  logic [CFG_AW-1:0]               rd_addr,
  output logic [ENTRY_W-1:0]              rd_data,
  output logic [N_ENTRIES-1:0][MODE_W-1:0]  mode_o,
  output logic [N_ENTRIES-1:0][NAPOT_W-1:0] napot_o
);

  logic [N_ENTRIES-1:0][MODE_W-1:0]  mode_q;
  logic [N_ENTRIES-1:0][NAPOT_W-1:0] napot_q;
  logic [ENTRY_W-1:0]                rd_mux;
  logic                              unused_rsv_bits;

  assign unused_rsv_bits = ^wr_data[MODE_LSB-1:NAPOT_W];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic wr_hit;
    assign wr_hit = wr_en && (wr_addr == CFG_AW'(g)) && !mode_q[g][MODE_W-1];

    always_ff @(posedge clk) begin
      if (rst) begin
        mode_q[g]  <= '0;
        napot_q[g] <= '0;
      end else if (wr_hit) begin
        mode_q[g]  <= wr_data[ENTRY_W-1:MODE_LSB];
        napot_q[g] <= wr_data[NAPOT_W-1:0];
      end
    end

    // R3: a locked entry holds its contents
    p_lock_hold_r3: assert property (@(posedge clk) disable iff (rst)
      mode_q[g][MODE_W-1] |=> ($stable(mode_q[g]) && $stable(napot_q[g])));
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (rd_addr == CFG_AW'(i))
        rd_mux = {mode_q[i], {(MODE_LSB-NAPOT_W){1'b0}}, napot_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end

  assign mode_o  = mode_q;
  assign napot_o = napot_q;

  // R2: gap bits never appear on the read port
  p_gap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    rd_data[MODE_LSB-1:NAPOT_W] == '0);

  // R4: reads past the bank return zero
  p_oob_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (int'(rd_addr) >= N_ENTRIES) |=> (rd_data == '0));

endmodule

// File: rtl/mpc_region_decode.sv
module mpc_region_decode
  import mpc_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [NAPOT_W-1:0] napot_i,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [2:0]         req_perm,
  output logic               hit_o,
  output logic               perm_ok_o
);

  mode_t              m;
  logic [TCNT_W-1:0]  ones;
  logic [NAPOT_W-1:0] low_mask;
  logic [ADDR_W-1:0]  base;
  logic [6:0]         shamt;
  logic [SPAN_W-1:0]  reg_lo, reg_hi, req_lo, req_hi;
  logic               unused_mode_bits;

  assign m                = mode_t'(mode_i);
  assign unused_mode_bits = m.lock ^ (^m.rsv);

  assign ones     = trail_ones(napot_i);
  assign low_mask = (NAPOT_W'(1) << ones) - NAPOT_W'(1);
  assign base     = {napot_i & ~low_mask, 2'b00};
  assign shamt    = 7'(ones) + 7'd3;

  assign reg_lo = SPAN_W'(base);
  assign reg_hi = reg_lo + (SPAN_W'(1) << shamt);
  assign req_lo = SPAN_W'(req_addr);
  assign req_hi = req_lo + SPAN_W'(req_len);

  assign hit_o     = (m.amode == AMODE_NAPOT) && (req_lo >= reg_lo) && (req_hi <= reg_hi);
  assign perm_ok_o = ({m.x, m.w, m.r} == req_perm);

endmodule

// File: rtl/mpc_prio_select.sv
module mpc_prio_select #(
  parameter int N_ENTRIES = 4,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_ENTRIES-1:0] hit_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [N_ENTRIES-1:0] sel_o
);

  always_comb begin
    idx_o = '0;
    sel_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        idx_o = IDX_W'(i);
        sel_o = N_ENTRIES'(1) << i;
      end
    end
  end

  assign any_o = |sel_o;

  // R9: at most one winner, and no containing entry below it
  p_one_winner_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_o));
  p_lowest_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ((sel_o - N_ENTRIES'(1)) & hit_i & ~sel_o) == '0 || sel_o == '0);
  p_any_matches_hits_r9: assert property (@(posedge clk) disable iff (rst)
    any_o == (hit_i != '0));

endmodule

// File: rtl/dma_napot_guard.sv
module dma_napot_guard
  import mpc_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int CFG_AW    = 3,
  parameter int LEN_W     = 16,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_waddr,
  input  logic [63:0]        cfg_wdata,
  input  logic [CFG_AW-1:0]  cfg_raddr,
  output logic [63:0]        cfg_rdata,
  input  logic               req_valid,
  input  logic [37:0]        req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [2:0]         req_perm,
  output logic               resp_valid,
  output logic               resp_grant,
  output logic               resp_hit,
  output logic [IDX_W-1:0]   resp_idx
);

  logic [N_ENTRIES-1:0][MODE_W-1:0]  ent_mode;
  logic [N_ENTRIES-1:0][NAPOT_W-1:0] ent_napot;
  logic [N_ENTRIES-1:0]              hit_vec, perm_vec, sel_vec;
  logic                              any_hit, grant_c;
  logic [IDX_W-1:0]                  win_idx;

  mpc_cfg_bank #(.N_ENTRIES(N_ENTRIES), .CFG_AW(CFG_AW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_addr (cfg_waddr),
    .wr_data (cfg_wdata),
    .rd_addr (cfg_raddr),
    .rd_data (cfg_rdata),
    .mode_o  (ent_mode),
    .napot_o (ent_napot)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_dec
    mpc_region_decode #(.LEN_W(LEN_W)) u_dec (
      .mode_i    (ent_mode[g]),
      .napot_i   (ent_napot[g]),
      .req_addr  (req_addr),
      .req_len   (req_len),
      .req_perm  (req_perm),
      .hit_o     (hit_vec[g]),
      .perm_ok_o (perm_vec[g])
    );
  end

  mpc_prio_select #(.N_ENTRIES(N_ENTRIES)) u_sel (
    .clk   (clk),
    .rst   (rst),
    .hit_i (hit_vec),
    .any_o (any_hit),
    .idx_o (win_idx),
    .sel_o (sel_vec)
  );

  assign grant_c = |(sel_vec & perm_vec);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_grant <= 1'b0;
      resp_hit   <= 1'b0;
      resp_idx   <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_grant <= req_valid && grant_c;
      resp_hit   <= req_valid && any_hit;
      resp_idx   <= req_valid ? win_idx : '0;
    end
  end

  // R10: one-cycle response, quiet outputs after idle cycles
  p_resp_follows_req_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !resp_grant && !resp_hit));
  // R8: a grant always comes from a containing entry
  p_grant_needs_hit_r8: assert property (@(posedge clk) disable iff (rst)
    resp_grant |-> resp_hit);
  // R9: no containing entry means index zero and deny
  p_nohit_deny_r9: assert property (@(posedge clk) disable iff (rst)
    !resp_hit |-> (resp_idx == '0 && !resp_grant));

endmodule

// File: tb/sim_dma_napot_guard.sv
module sim_dma_napot_guard;

  localparam int N  = 4;
  localparam int AW = 3;
  localparam int LW = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [AW-1:0] cfg_waddr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_raddr = '0;
  logic [63:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [37:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [2:0]  req_perm = '0;
  logic        resp_valid, resp_grant, resp_hit;
  logic [1:0]  resp_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dma_napot_guard #(.N_ENTRIES(N), .CFG_AW(AW), .LEN_W(LW)) u0 (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_perm(req_perm),
    .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_hit(resp_hit), .resp_idx(resp_idx)
  );

  typedef struct packed {
    logic [37:0] addr;
    logic [15:0] len;
    logic [2:0]  perm;
    logic        grant;
    logic        hit;
    logic [1:0]  idx;
  } vec_t;

  // Entries: 0=[0x1000,+4K) R, 1=[0x10000,+64K) RW, 2=[0,+1M) RWX, 3=[0x200000,+8K) X
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{38'h1000,    16'd8,      3'd1, 1'b1, 1'b1, 2'd0},  // R7 inside entry 0
    '{38'h1000,    16'd8,      3'd3, 1'b0, 1'b1, 2'd0},  // R8 R9 subset rights, entry 0 decides
    '{38'h1FF8,    16'd8,      3'd1, 1'b1, 1'b1, 2'd0},  // R7 ends exactly at top
    '{38'h1FF8,    16'd16,     3'd1, 1'b0, 1'b1, 2'd2},  // R7 spills, entry 2 decides
    '{38'h1FF8,    16'd16,     3'd7, 1'b1, 1'b1, 2'd2},  // R9 entry 2 grants
    '{38'h1F000,   16'h1000,   3'd3, 1'b1, 1'b1, 2'd1},  // R6 64K region top
    '{38'h200100,  16'd4,      3'd4, 1'b1, 1'b1, 2'd3},  // R5 execute only
    '{38'h300000,  16'd4,      3'd7, 1'b0, 1'b0, 2'd0},  // R9 no entry
    '{38'hFFFFC,   16'd4,      3'd7, 1'b1, 1'b1, 2'd2},  // R7 1M top inclusive
    '{38'hFFFFC,   16'd8,      3'd7, 1'b0, 1'b0, 2'd0},  // R7 one word past
    '{38'h0FF8,    16'd16,     3'd7, 1'b1, 1'b1, 2'd2},  // R7 starts below entry 0
    '{38'h0FFFC,   16'd4,      3'd3, 1'b0, 1'b1, 2'd2}   // R6 below entry 1 base
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [63:0] d);
    @(negedge clk);
    cfg_raddr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic rq(input logic [37:0] a, input logic [15:0] l, input logic [2:0] p,
                    output logic [4:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_perm = p;
    @(negedge clk);
    r = {resp_valid, resp_grant, resp_hit, resp_idx};
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [63:0] d;
    logic [4:0]  r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(3'd0, d);  chk("R1 entry0 after reset", d, 64'h0);
    rd(3'd3, d);  chk("R1 entry3 after reset", d, 64'h0);
    rq(38'h1000, 16'd8, 3'd1, r);
    chk("R1 deny after reset", 64'(r), 64'({1'b1, 1'b0, 1'b0, 2'd0}));
    @(negedge clk);
    chk("R10 idle resp_valid", 64'(resp_valid), 64'd0);

    // program bank; entry 1 carries junk in the gap bits
    wr(3'd0, 64'h1900_0000_0000_05FF);
    wr(3'd1, 64'h1BAB_CDE0_0000_5FFF);
    wr(3'd2, 64'h1F00_0000_0001_FFFF);
    wr(3'd3, 64'h1C00_0000_0008_03FF);
    rd(3'd1, d);  chk("R2 gap bits cleared", d, 64'h1B00_0000_0000_5FFF);
    rd(3'd2, d);  chk("R2 entry2 readback", d, 64'h1F00_0000_0001_FFFF);

    // table walk: R6 R7 R8 R9 R10
    for (int k = 0; k < NV; k++) begin
      rq(VEC[k].addr, VEC[k].len, VEC[k].perm, r);
      chk($sformatf("R7 R8 R9 vec%0d", k), 64'(r[3:0]),
          64'({VEC[k].grant, VEC[k].hit, VEC[k].idx}));
      chk($sformatf("R10 vec%0d valid", k), 64'(r[4]), 64'd1);
    end

    // R3: lock entry 3 then try to rewrite it
    wr(3'd3, 64'h9C00_0000_0008_03FF);
    wr(3'd3, 64'h1F00_0000_0000_0FFF);
    rd(3'd3, d);  chk("R3 locked entry unchanged", d, 64'h9C00_0000_0008_03FF);
    rq(38'h200100, 16'd4, 3'd4, r);
    chk("R3 locked entry still decides", 64'(r), 64'({1'b1, 1'b1, 1'b1, 2'd3}));
    rq(38'h0, 16'd4, 3'd7, r);
    chk("R3 rewrite had no effect", 64'(r), 64'({1'b1, 1'b1, 1'b1, 2'd2}));

    // R4: writes and reads past the bank
    wr(3'd5, 64'h0);
    wr(3'd4, 64'h1F00_0000_0000_0FFF);
    rd(3'd1, d);  chk("R4 oob write no alias", d, 64'h1B00_0000_0000_5FFF);
    rd(3'd0, d);  chk("R4 oob write entry0", d, 64'h1900_0000_0000_05FF);
    rd(3'd6, d);  chk("R4 oob read zero", d, 64'h0);
    rq(38'h10000, 16'd4, 3'd3, r);
    chk("R4 entry1 still active", 64'(r), 64'({1'b1, 1'b1, 1'b1, 2'd1}));

    // R6: 35 trailing ones cover 2^38 bytes from zero
    wr(3'd1, 64'h1B00_0007_FFFF_FFFF);
    rq(38'h3F_0000_0000, 16'd16, 3'd3, r);
    chk("R6 largest region", 64'(r), 64'({1'b1, 1'b1, 1'b1, 2'd1}));

    // R5: address mode 1 disables entry 1
    wr(3'd1, 64'h0B00_0000_0000_5FFF);
    rq(38'h10000, 16'd4, 3'd3, r);
    chk("R5 non-NAPOT mode inactive", 64'(r), 64'({1'b1, 1'b0, 1'b1, 2'd2}));

    done = 1'b1;
    finish_run();
  end

endmodule